// File: doc/BRIEF.md
# Single-Frame Snapshot Rate Matcher

This block decouples a fast pixel stream from a slow consumer. While armed, it waits for a frame-start, then writes every valid pixel of that one frame, in arrival order, into an on-chip memory with two clocks. When the last pixel of the frame has arrived, it holds the picture and tells the consumer, on the consumer's own clock, that a frame is ready. The consumer pulls pixels one per read strobe, at any rate it likes.

While a picture is held, every further frame is thrown away whole. When the consumer is finished it pulses a rearm input. The block then drops its ready indication, forgets the old picture and locks onto the start of the next frame. It never begins in the middle of a frame. A frame-start seen during capture means the partial frame is abandoned and capture restarts at the first location.

An elaboration option lets the consumer begin reading while the frame is still arriving. In that mode, a read is only honoured when its pixel has already been stored.

Top module: `frame_snapshot_buffer`

## Requirements
- R1: After reset, frame_ready, rd_done and rd_valid are 0 and rd_data is zero. A read strobe before any frame is held returns rd_valid 0.
- R2: While armed, pixels presented without a frame-start (pix_sof=1 together with pix_valid=1) are ignored. Capture begins with the pixel that carries the frame-start.
- R3: During capture, only cycles with pix_valid=1 store a pixel, at consecutive locations starting at 0. Once H_PIX*V_LINES pixels are stored, the frame is held and frame_ready rises on the read side.
- R4: While a frame is held, incoming frames are dropped, and the held pixels read out unchanged.
- R5: A frame-start during capture discards the partial frame. The pixel carrying that frame-start is stored at location 0.
- R6: Each read strobe for an available pixel returns the next stored pixel on rd_data with rd_valid=1, one read-clock edge after the strobe is sampled. Pixels come out in capture order.
- R7: Once all pixels have been read, rd_done is 1. A further strobe returns rd_data zero and rd_valid 0, and the read position does not move.
- R8: A rearm pulse while frame_ready is 1 drops frame_ready and rd_done at the edge that samples it. The block then captures the next frame from its start.
- R9: A rearm pulse while frame_ready is 0 has no effect.
- R10: With EARLY_READ=1, reads may proceed during capture. A strobe for a pixel not yet stored returns rd_valid 0 and zero data, and does not advance. The pixels delivered are exactly the frame in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel-side clock |
| pix_rst_n | input | 1 | Pixel-side active-low reset |
| pix_sof | input | 1 | Marks the first pixel of a frame (qualified by pix_valid) |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | PIX_W | Pixel value |
| rd_clk | input | 1 | Consumer-side clock |
| rd_rst_n | input | 1 | Consumer-side active-low reset |
| rd_strobe | input | 1 | Request the next pixel |
| rearm | input | 1 | Consumer finished; release the held frame |
| rd_data | output | PIX_W | Returned pixel, zero when none was returned |
| rd_valid | output | 1 | rd_data carries a pixel from the last strobe |
| frame_ready | output | 1 | A complete frame is held for readout |
| rd_done | output | 1 | Every pixel of the held frame has been read |

## Verification
The read data and rd_valid are registered on the read-clock edge that samples the strobe. The bench drives the strobe at a falling read-clock edge and checks the result at the next falling edge. frame_ready reaches the read side through a two-stage synchroniser, so it trails the last stored pixel by two to three read edges; the bench waits several read cycles before checking it. A rearm removes frame_ready and rd_done at the very edge that samples it, and the bench checks this at the next falling edge. Re-arming the pixel side takes a few further cycles of both clocks, so the bench waits those out before sending the next frame.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
   typedef enum logic [1:0] {
      ST_ARMED   = 2'd0,
      ST_CAPTURE = 2'd1,
      ST_HELD    = 2'd2
   } cap_state_e;
endpackage

// File: rtl/fsb_sync.sv
module fsb_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("fsb_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
      end else begin
         chain_q[0] <= d;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fsb_dpram.sv
module fsb_dpram #(
   parameter int DW    = 24,
   parameter int DEPTH = 2048,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic          rclk,
   input  logic          re,
   input  logic [AW-1:0] ra,
   output logic [DW-1:0] rq
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[wa] <= wd;
   end

   always_ff @(posedge rclk) begin
      if (re) rq <= mem[ra];
   end
endmodule

// File: rtl/fsb_capture.sv
module fsb_capture
   import fsb_pkg::*;
#(
   parameter int PIX_W      = 24,
   parameter int N          = 2048,
   parameter bit EARLY_READ = 1'b0,
   localparam int AW        = $clog2(N),
   localparam int CW        = $clog2(N + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof,
   input  logic             valid,
   input  logic [PIX_W-1:0] data,
   input  logic             rearm_evt,
   output logic             we,
   output logic [AW-1:0]    wa,
   output logic [PIX_W-1:0] wd,
   output logic             held,
   output logic [CW-1:0]    wr_gray
);
   localparam logic [CW-1:0] LAST = CW'(N - 1);
   localparam logic [CW-1:0] FULL = CW'(N);

   cap_state_e    st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          start;

   assign start = sof && valid;
   assign wd    = data;
   assign held  = (st_q == ST_HELD);

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      we    = 1'b0;
      wa    = '0;
      unique case (st_q)
         ST_ARMED: begin
            if (start) begin
               we    = 1'b1;
               cnt_d = CW'(1);
               st_d  = ST_CAPTURE;
            end
         end
         ST_CAPTURE: begin
            if (start) begin
               we    = 1'b1;
               cnt_d = CW'(1);
            end else if (valid) begin
               we    = 1'b1;
               wa    = cnt_q[AW-1:0];
               cnt_d = cnt_q + CW'(1);
               if (cnt_q == LAST) st_d = ST_HELD;
            end
         end
         ST_HELD: begin
            if (rearm_evt) begin
               st_d  = ST_ARMED;
               cnt_d = '0;
            end
         end
         default: st_d = ST_ARMED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_ARMED;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   generate
      if (EARLY_READ) begin : g_gray
         logic [CW-1:0] gray_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) gray_q <= '0;
            else        gray_q <= cnt_d ^ (cnt_d >> 1);
         end
         assign wr_gray = gray_q;
      end else begin : g_nogray
         assign wr_gray = '0;
      end
   endgenerate

   AST_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HELD) |-> !we); // R4
   AST_FIRST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (start && st_q != ST_HELD) |-> (we && wa == '0)); // R5
   AST_ARMED_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ARMED && !start) |=> (st_q == ST_ARMED)); // R2
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL); // R3
   AST_HELD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CAPTURE && valid && !sof && cnt_q == LAST) |=> (st_q == ST_HELD)); // R3
endmodule

// File: rtl/fsb_drain.sv
module fsb_drain #(
   parameter int PIX_W      = 24,
   parameter int N          = 2048,
   parameter bit EARLY_READ = 1'b0,
   localparam int AW        = $clog2(N),
   localparam int CW        = $clog2(N + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_strobe,
   input  logic             rearm,
   input  logic             held_s,
   input  logic [CW-1:0]    gray_s,
   output logic             re,
   output logic [AW-1:0]    ra,
   input  logic [PIX_W-1:0] rq,
   output logic [PIX_W-1:0] rd_data,
   output logic             rd_valid,
   output logic             frame_ready,
   output logic             rd_done,
   output logic             rearm_tog
);
   localparam logic [CW-1:0] FULL = CW'(N);

   logic [CW-1:0] addr_q;
   logic [CW-1:0] cnt_bin;
   logic [CW-1:0] avail;
   logic [CW-1:0] avail_eff;
   logic          wait_q;
   logic          took_q;
   logic          tog_q;
   logic          take;
   logic          accept;

   always_comb begin
      for (int i = 0; i < CW; i++) cnt_bin[i] = ^(gray_s >> i);
   end

   generate
      if (EARLY_READ) begin : g_early
         assign avail = cnt_bin;
      end else begin : g_whole
         assign avail = held_s ? FULL : '0;
      end
   endgenerate

   assign avail_eff   = wait_q ? '0 : avail;
   assign frame_ready = held_s && !wait_q;
   assign accept      = rearm && frame_ready;
   assign take        = rd_strobe && !accept && (addr_q < avail_eff);
   assign re          = take;
   assign ra          = addr_q[AW-1:0];
   assign rd_valid    = took_q;
   assign rd_data     = took_q ? rq : '0;
   assign rd_done     = frame_ready && (addr_q == FULL);
   assign rearm_tog   = tog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         wait_q <= 1'b0;
         took_q <= 1'b0;
         tog_q  <= 1'b0;
      end else if (accept) begin
         addr_q <= '0;
         wait_q <= 1'b1;
         took_q <= 1'b0;
         tog_q  <= ~tog_q;
      end else begin
         if (wait_q && !held_s && cnt_bin == '0) wait_q <= 1'b0;
         if (rd_strobe) begin
            took_q <= take;
            if (take) addr_q <= addr_q + CW'(1);
         end
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      $rose(rst_n) |-> (!rd_valid && rd_data == '0)); // R1
   AST_STEP_MATCHES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !rearm) |=> (rd_valid == (addr_q != $past(addr_q)))); // R6
   AST_PAST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !rearm && addr_q == FULL) |=> (!rd_valid && rd_data == '0 && addr_q == FULL)); // R7
   AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      addr_q <= FULL); // R7
   AST_REARM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rearm && frame_ready) |=> (!frame_ready && !rd_done)); // R8
   AST_REARM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (rearm && !frame_ready) |=> $stable(tog_q)); // R9
   AST_NO_OVERTAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !held_s && EARLY_READ == 1'b0) |=> !rd_valid); // R10
endmodule

// File: rtl/frame_snapshot_buffer.sv
module frame_snapshot_buffer #(
   parameter int PIX_W      = 24,
   parameter int H_PIX      = 64,
   parameter int V_LINES    = 32,
   parameter bit EARLY_READ = 1'b0,
   parameter int SYNC_STG   = 2
) (
   input  logic             pix_clk,
   input  logic             pix_rst_n,
   input  logic             pix_sof,
   input  logic             pix_valid,
   input  logic [PIX_W-1:0] pix_data,
   input  logic             rd_clk,
   input  logic             rd_rst_n,
   input  logic             rd_strobe,
   input  logic             rearm,
   output logic [PIX_W-1:0] rd_data,
   output logic             rd_valid,
   output logic             frame_ready,
   output logic             rd_done
);
   localparam int N  = H_PIX * V_LINES;
   localparam int AW = $clog2(N);
   localparam int CW = $clog2(N + 1);

   generate
      if (PIX_W < 1)   begin : g_chk_w $error("PIX_W must be positive"); end
      if (N < 2)       begin : g_chk_n $error("frame must hold at least two pixels"); end
      if (SYNC_STG < 2) begin : g_chk_s $error("SYNC_STG must be at least two"); end
   endgenerate

   logic             we;
   logic [AW-1:0]    wa;
   logic [PIX_W-1:0] wd;
   logic             re;
   logic [AW-1:0]    ra;
   logic [PIX_W-1:0] rq;
   logic             held;
   logic             held_s;
   logic [CW-1:0]    wr_gray;
   logic [CW-1:0]    gray_s;
   logic             tog_rd;
   logic             tog_s;
   logic             tog_seen_q;
   logic             rearm_evt;

   fsb_capture #(.PIX_W(PIX_W), .N(N), .EARLY_READ(EARLY_READ)) u_cap (
      .clk(pix_clk), .rst_n(pix_rst_n), .sof(pix_sof), .valid(pix_valid),
      .data(pix_data), .rearm_evt(rearm_evt), .we(we), .wa(wa), .wd(wd),
      .held(held), .wr_gray(wr_gray)
   );

   fsb_dpram #(.DW(PIX_W), .DEPTH(N)) u_mem (
      .wclk(pix_clk), .we(we), .wa(wa), .wd(wd),
      .rclk(rd_clk), .re(re), .ra(ra), .rq(rq)
   );

   fsb_sync #(.W(1), .STAGES(SYNC_STG)) u_held_sync (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(held), .q(held_s)
   );

   fsb_sync #(.W(1), .STAGES(SYNC_STG)) u_tog_sync (
      .clk(pix_clk), .rst_n(pix_rst_n), .d(tog_rd), .q(tog_s)
   );

   generate
      if (EARLY_READ) begin : g_cnt_xing
         fsb_sync #(.W(CW), .STAGES(SYNC_STG)) u_gray_sync (
            .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(gray_s)
         );
      end else begin : g_no_xing
         assign gray_s = wr_gray;
      end
   endgenerate

   always_ff @(posedge pix_clk or negedge pix_rst_n) begin
      if (!pix_rst_n) tog_seen_q <= 1'b0;
      else            tog_seen_q <= tog_s;
   end
   assign rearm_evt = tog_s ^ tog_seen_q;

   fsb_drain #(.PIX_W(PIX_W), .N(N), .EARLY_READ(EARLY_READ)) u_drain (
      .clk(rd_clk), .rst_n(rd_rst_n), .rd_strobe(rd_strobe), .rearm(rearm),
      .held_s(held_s), .gray_s(gray_s), .re(re), .ra(ra), .rq(rq),
      .rd_data(rd_data), .rd_valid(rd_valid), .frame_ready(frame_ready),
      .rd_done(rd_done), .rearm_tog(tog_rd)
   );

   AST_READY_NEEDS_HELD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      frame_ready |-> held_s); // R3
endmodule

// File: tb/tb_frame_snapshot_buffer.sv
`timescale 1ns/1ps
module tb_frame_snapshot_buffer;
   localparam int PW = 24;
   localparam int H  = 8;
   localparam int V  = 4;
   localparam int N  = H * V;

   logic pix_clk = 1'b0;
   logic rd_clk  = 1'b0;
   logic pix_rst_n = 1'b0;
   logic rd_rst_n  = 1'b0;
   logic pv = 1'b0, ps = 1'b0, sel_e = 1'b0;
   logic [PW-1:0] pd = '0;
   logic strobe = 1'b0, rearm = 1'b0;
   logic strobe_e = 1'b0, rearm_e = 1'b0;
   logic [PW-1:0] rd_data, rd_data_e;
   logic rd_valid, frame_ready, rd_done;
   logic rd_valid_e, frame_ready_e, rd_done_e;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #10 pix_clk = ~pix_clk;
   initial begin
      #7;
      forever #65 rd_clk = ~rd_clk;
   end

   frame_snapshot_buffer #(.PIX_W(PW), .H_PIX(H), .V_LINES(V)) dut (
      .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .pix_sof(ps && !sel_e),
      .pix_valid(pv && !sel_e), .pix_data(pd), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
      .rd_strobe(strobe), .rearm(rearm), .rd_data(rd_data), .rd_valid(rd_valid),
      .frame_ready(frame_ready), .rd_done(rd_done)
   );

   frame_snapshot_buffer #(.PIX_W(PW), .H_PIX(H), .V_LINES(V), .EARLY_READ(1'b1)) dut_early (
      .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .pix_sof(ps && sel_e),
      .pix_valid(pv && sel_e), .pix_data(pd), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
      .rd_strobe(strobe_e), .rearm(rearm_e), .rd_data(rd_data_e), .rd_valid(rd_valid_e),
      .frame_ready(frame_ready_e), .rd_done(rd_done_e)
   );

   function automatic logic [PW-1:0] pix(input logic [7:0] tag, input int idx);
      return {tag, 16'(idx)};
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] tag, input int first, input int cnt,
                       input bit with_sof, input int gap);
      for (int i = 0; i < cnt; i++) begin
         @(negedge pix_clk);
         pv = 1'b1;
         ps = with_sof && (i == 0);
         pd = pix(tag, first + i);
         for (int g = 0; g < gap; g++) begin
            @(negedge pix_clk);
            pv = 1'b0;
            ps = 1'b0;
            pd = 24'hBADBAD;
         end
      end
      @(negedge pix_clk);
      pv = 1'b0;
      ps = 1'b0;
   endtask

   task automatic rd_wait(input int n);
      for (int i = 0; i < n; i++) @(negedge rd_clk);
   endtask

   task automatic read_one;
      @(negedge rd_clk);
      strobe = 1'b1;
      @(negedge rd_clk);
      strobe = 1'b0;
   endtask

   task automatic pulse_rearm;
      @(negedge rd_clk);
      rearm = 1'b1;
      @(negedge rd_clk);
      rearm = 1'b0;
   endtask

   task automatic read_frame(input logic [7:0] tag, input string req);
      int bad = 0;
      for (int i = 0; i < N; i++) begin
         read_one();
         if (!rd_valid || rd_data !== pix(tag, i)) begin
            bad++;
            if (bad == 1) check(1'b0, req, rd_data, pix(tag, i));
         end
      end
      if (bad == 0) check(1'b1, req, 0, 0);
   endtask

   task automatic t_reset;
      check(frame_ready == 1'b0, "R1 frame_ready", frame_ready, 0);
      check(rd_done == 1'b0, "R1 rd_done", rd_done, 0);
      check(rd_valid == 1'b0 && rd_data == '0, "R1 rd_data", rd_data, 0);
      read_one();
      check(rd_valid == 1'b0, "R1 strobe before frame", rd_valid, 0);
   endtask

   task automatic t_capture;
      pulse_rearm();
      rd_wait(4);
      check(frame_ready == 1'b0, "R9 rearm while empty", frame_ready, 0);
      send(8'hEE, 100, 5, 1'b0, 0);      // R2 mid-frame tail ignored
      send(8'h01, 0, N, 1'b1, 1);        // R3 gaps between pixels
      rd_wait(5);
      check(frame_ready == 1'b1, "R3 frame_ready after capture", frame_ready, 1);
      check(rd_done == 1'b0, "R3 rd_done low before reading", rd_done, 0);
   endtask

   task automatic t_drop_and_read;
      send(8'h02, 0, N, 1'b1, 0);        // R4 frame while held
      rd_wait(3);
      check(frame_ready == 1'b1, "R4 still ready", frame_ready, 1);
      read_frame(8'h01, "R4 R6 held frame read out");
      check(rd_done == 1'b1, "R7 rd_done after last", rd_done, 1);
      read_one();
      check(rd_valid == 1'b0 && rd_data == '0, "R7 read past end", rd_data, 0);
      check(rd_done == 1'b1, "R7 done holds", rd_done, 1);
   endtask

   task automatic t_rearm_restart;
      pulse_rearm();
      check(frame_ready == 1'b0 && rd_done == 1'b0, "R8 rearm drops flags",
            {frame_ready, rd_done}, 0);
      rd_wait(6);
      send(8'hEE, 200, 3, 1'b0, 0);      // R2 tail before first sof
      send(8'h03, 0, 10, 1'b1, 0);       // partial frame
      send(8'h04, 0, N, 1'b1, 2);        // R5 restart at zero
      rd_wait(5);
      check(frame_ready == 1'b1, "R8 next frame captured", frame_ready, 1);
      read_frame(8'h04, "R5 R8 restarted frame");
   endtask

   task automatic t_early;
      int got = 0;
      int stalls = 0;
      int bad = 0;
      @(negedge rd_clk);
      strobe_e = 1'b1;
      @(negedge rd_clk);
      check(rd_valid_e == 1'b0 && rd_data_e == '0, "R10 read before any pixel", rd_data_e, 0);
      sel_e = 1'b1;
      fork
         send(8'h07, 0, N, 1'b1, 12);
         begin
            for (int it = 0; it < 800 && got < N; it++) begin
               @(negedge rd_clk);
               if (rd_valid_e) begin
                  if (rd_data_e !== pix(8'h07, got)) begin
                     bad++;
                     if (bad == 1) check(1'b0, "R10 early order", rd_data_e, pix(8'h07, got));
                  end
                  got++;
               end else begin
                  stalls++;
                  if (rd_data_e != '0) begin
                     bad++;
                     check(1'b0, "R10 stall data", rd_data_e, 0);
                  end
               end
            end
            strobe_e = 1'b0;
         end
      join
      sel_e = 1'b0;
      check(got == N, "R10 all pixels delivered", got, N);
      check(stalls > 0, "R10 reader stalled behind writer", stalls, 1);
      check(bad == 0, "R10 early data", bad, 0);
      rd_wait(4);
      check(rd_done_e == 1'b1, "R10 done after full frame", rd_done_e, 1);
   endtask

   initial begin
      #100;
      pix_rst_n = 1'b1;
      rd_rst_n  = 1'b1;
      rd_wait(2);
      t_reset();
      t_capture();
      t_drop_and_read();
      t_rearm_restart();
      t_early();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge pix_clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule